// File: doc/BRIEF.md
# Register-Pair Pointer Address Unit

This block is a general register file of 8-bit entries in which the top six registers double as three 16-bit data-memory pointers. Every register can be read through two independent read ports and written through one ordinary write port. The pointer pairs stay ordinary registers when no access uses them, so a compiler can treat them as byte or word working storage.

A pointer command picks one pair and an addressing mode. The block forms the effective address for a data-memory access and, where the mode calls for it, writes the new pointer value back to both bytes of the pair in the same clock. Four addressing modes are supported: plain indirect, post-increment, pre-decrement and indirect with a 6-bit unsigned displacement. Two further commands add or subtract a 6-bit constant to a whole pair in one clock. The effective address, its valid flag and a write-back strobe are registered outputs. The data memory, instruction decode and the stack are outside this block.

Top module: `ptr_addr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared to zero, and `ea_out`, `ea_valid`, `pair_upd`, `rd_a_data` and `rd_b_data` go to zero after that edge.
- R2: When `wr_en` is high, `wr_data` is stored in register `wr_sel`. Each read port returns, one clock after its select is presented, the register contents from before any write at that same edge (read-first).
- R3: Pair k (`ptr_sel` 0, 1, 2) is the register pair {R(27+2k), R(26+2k)}, with the low byte in the even register. Plain mode (`ptr_mode` 0) gives `ea_out` equal to the pair one clock later with `ea_valid` high, and it leaves the pair unchanged.
- R4: Post-increment (`ptr_mode` 1) gives `ea_out` equal to the old pair value and writes back the old value plus one, modulo 2^16.
- R5: Pre-decrement (`ptr_mode` 2) gives `ea_out` equal to the old value minus one, modulo 2^16, and writes that same value back.
- R6: Displacement (`ptr_mode` 3) gives `ea_out` equal to the pair plus `ptr_imm` zero-extended (0 to 63), and it leaves the pair unchanged.
- R7: Add (`ptr_mode` 4) and subtract (`ptr_mode` 5) write back the pair plus or minus `ptr_imm`. The carry or borrow passes from the low byte into the high byte and the result wraps modulo 2^16. `ea_valid` stays low for these commands.
- R8: `pair_upd` is high in the clock after a command that wrote a pair back (modes 1, 2, 4 and 5), and low at all other times.
- R9: If an ordinary write and a pointer write-back target the same register at one edge, the write-back value is stored. An ordinary write to a pair register that is not being updated at that edge takes effect as usual.
- R10: A command with `ptr_sel` equal to 3, or with `ptr_mode` equal to 6 or 7, is ignored. `ea_valid` and `pair_upd` stay low and all pairs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 5 | Read port A register select |
| rd_a_data | output | 8 | Read port A data, registered |
| rd_b_sel | input | 5 | Read port B register select |
| rd_b_data | output | 8 | Read port B data, registered |
| wr_en | input | 1 | Ordinary write enable |
| wr_sel | input | 5 | Ordinary write register select |
| wr_data | input | 8 | Ordinary write data |
| ptr_go | input | 1 | Pointer command valid |
| ptr_sel | input | 2 | Pointer pair select (0..2 valid) |
| ptr_mode | input | 3 | Pointer command mode (0..5 valid) |
| ptr_imm | input | 6 | Displacement or add/subtract constant |
| ea_out | output | 16 | Effective address, registered |
| ea_valid | output | 1 | Effective address valid |
| pair_upd | output | 1 | A pointer pair was written back |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, three pairs starting at register 26, and a 6-bit immediate. With these values the highest pair ends on the last register. A displacement of 63 and carries from a low byte of 0xF0 into the high byte can be driven, and the 16-bit wrap at 0xFFFF and 0x0000 can be reached with a single step. A scoreboard predicts the address, valid flag and strobe for every command, including back-to-back updates and collisions with the ordinary write port.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  typedef enum logic [2:0] {
    PM_PLAIN   = 3'd0,
    PM_POSTINC = 3'd1,
    PM_PREDEC  = 3'd2,
    PM_DISP    = 3'd3,
    PM_ADD     = 3'd4,
    PM_SUB     = 3'd5
  } ptr_mode_e;

  localparam logic [2:0] PM_LAST = 3'd5;

endpackage

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
  import ptr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMM_W = 6
) (
  input  logic            cmd_ok,
  input  logic [2:0]      mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [2*DW-1:0] ptr_val,
  output logic [2*DW-1:0] ea,
  output logic            ea_vld,
  output logic            wb_en,
  output logic [2*DW-1:0] wb_val
);

  logic [DW-1:0] lo, hi;
  logic [DW-1:0] step;
  logic          do_sub;
  logic [DW:0]   lo_ext;
  logic          cy;
  logic [DW-1:0] hi_n;
  logic [2*DW-1:0] adj;

  assign lo = ptr_val[DW-1:0];
  assign hi = ptr_val[2*DW-1:DW];

  always_comb begin
    step   = '0;
    do_sub = 1'b0;
    case (mode)
      PM_POSTINC: step = DW'(1);
      PM_PREDEC: begin
        step   = DW'(1);
        do_sub = 1'b1;
      end
      PM_DISP, PM_ADD: step = DW'(imm);
      PM_SUB: begin
        step   = DW'(imm);
        do_sub = 1'b1;
      end
      default: step = '0;
    endcase
  end

  // byte-wise adder: low byte first, carry/borrow into the high byte
  always_comb begin
    if (do_sub) begin
      lo_ext = {1'b0, lo} - {1'b0, step};
      cy     = lo_ext[DW];
      hi_n   = hi - DW'(cy);
    end else begin
      lo_ext = {1'b0, lo} + {1'b0, step};
      cy     = lo_ext[DW];
      hi_n   = hi + DW'(cy);
    end
    adj = {hi_n, lo_ext[DW-1:0]};
  end

  always_comb begin
    ea     = ptr_val;
    ea_vld = 1'b0;
    wb_en  = 1'b0;
    wb_val = adj;
    if (cmd_ok) begin
      case (mode)
        PM_PLAIN:   ea_vld = 1'b1;
        PM_POSTINC: begin
          ea_vld = 1'b1;
          wb_en  = 1'b1;
        end
        PM_PREDEC: begin
          ea     = adj;
          ea_vld = 1'b1;
          wb_en  = 1'b1;
        end
        PM_DISP: begin
          ea     = adj;
          ea_vld = 1'b1;
        end
        PM_ADD, PM_SUB: wb_en = 1'b1;
        default: ea_vld = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ptr_regbank.sv
module ptr_regbank #(
  parameter int NUM_REGS = 32,
  parameter int DW       = 8,
  parameter int PTR_BASE = 26,
  parameter int NUM_PTRS = 3,
  parameter int SEL_W    = $clog2(NUM_REGS),
  parameter int PSEL_W   = $clog2(NUM_PTRS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DW-1:0]                  wr_data,
  input  logic                           pb_en,
  input  logic [PSEL_W-1:0]              pb_idx,
  input  logic [2*DW-1:0]                pb_val,
  output logic [NUM_REGS-1:0][DW-1:0]    regs_o,
  output logic [NUM_PTRS-1:0][2*DW-1:0]  pairs_o
);

  localparam int PTR_END = PTR_BASE + 2 * NUM_PTRS;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          wr_hit;
    assign wr_hit = wr_en && (wr_sel == SEL_W'(g));

    if (g >= PTR_BASE && g < PTR_END) begin : g_ptr
      localparam int PI = (g - PTR_BASE) / 2;
      localparam int HB = (g - PTR_BASE) % 2;
      logic pb_hit;
      assign pb_hit = pb_en && (pb_idx == PSEL_W'(PI));
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (pb_hit) q <= pb_val[HB*DW +: DW];
        else if (wr_hit) q <= wr_data;
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (wr_hit) q <= wr_data;
      end
    end

    assign regs_o[g] = q;
  end

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_pair
    assign pairs_o[p] = {regs_o[PTR_BASE + 2*p + 1], regs_o[PTR_BASE + 2*p]};
  end

endmodule

// File: rtl/ptr_rd_port.sv
module ptr_rd_port #(
  parameter int NUM_REGS = 32,
  parameter int DW       = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SEL_W-1:0]            sel,
  input  logic [NUM_REGS-1:0][DW-1:0] regs_i,
  output logic [DW-1:0]               data_o
);

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= regs_i[sel];
  end

endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DW       = 8,
  parameter int PTR_BASE = 26,
  parameter int NUM_PTRS = 3,
  parameter int IMM_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_a_sel,
  output logic [DW-1:0]                 rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_b_sel,
  output logic [DW-1:0]                 rd_b_data,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]   wr_sel,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          ptr_go,
  input  logic [$clog2(NUM_PTRS)-1:0]   ptr_sel,
  input  logic [2:0]                    ptr_mode,
  input  logic [IMM_W-1:0]              ptr_imm,
  output logic [2*DW-1:0]               ea_out,
  output logic                          ea_valid,
  output logic                          pair_upd
);

  localparam int SEL_W  = $clog2(NUM_REGS);
  localparam int PSEL_W = $clog2(NUM_PTRS);
  localparam int AW     = 2 * DW;
  localparam int N_RD   = 2;

  logic [NUM_REGS-1:0][DW-1:0] regs;
  logic [NUM_PTRS-1:0][AW-1:0] pairs;
  logic                        sel_ok;
  logic                        cmd_ok;
  logic [PSEL_W-1:0]           idx;
  logic [AW-1:0]               cur_ptr;
  logic [AW-1:0]               ea_d;
  logic                        ea_vld_d;
  logic                        wb_en;
  logic [AW-1:0]               wb_val;

  assign sel_ok  = {1'b0, ptr_sel} < (PSEL_W+1)'(NUM_PTRS);
  assign cmd_ok  = ptr_go && sel_ok;
  assign idx     = sel_ok ? ptr_sel : '0;
  assign cur_ptr = pairs[idx];

  ptr_regbank #(
    .NUM_REGS (NUM_REGS),
    .DW       (DW),
    .PTR_BASE (PTR_BASE),
    .NUM_PTRS (NUM_PTRS),
    .SEL_W    (SEL_W),
    .PSEL_W   (PSEL_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pb_en   (wb_en),
    .pb_idx  (idx),
    .pb_val  (wb_val),
    .regs_o  (regs),
    .pairs_o (pairs)
  );

  ptr_addr_calc #(
    .DW    (DW),
    .IMM_W (IMM_W)
  ) u_calc (
    .cmd_ok  (cmd_ok),
    .mode    (ptr_mode),
    .imm     (ptr_imm),
    .ptr_val (cur_ptr),
    .ea      (ea_d),
    .ea_vld  (ea_vld_d),
    .wb_en   (wb_en),
    .wb_val  (wb_val)
  );

  logic [N_RD-1:0][SEL_W-1:0] rsel;
  logic [N_RD-1:0][DW-1:0]    rdat;
  assign rsel[0] = rd_a_sel;
  assign rsel[1] = rd_b_sel;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    ptr_rd_port #(
      .NUM_REGS (NUM_REGS),
      .DW       (DW),
      .SEL_W    (SEL_W)
    ) u_rd (
      .clk    (clk),
      .rst    (rst),
      .sel    (rsel[p]),
      .regs_i (regs),
      .data_o (rdat[p])
    );
  end

  assign rd_a_data = rdat[0];
  assign rd_b_data = rdat[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_out   <= '0;
      ea_valid <= 1'b0;
      pair_upd <= 1'b0;
    end else begin
      ea_out   <= ea_vld_d ? ea_d : ea_out;
      ea_valid <= ea_vld_d;
      pair_upd <= wb_en;
    end
  end

endmodule

// File: rtl/ptr_addr_unit_chk.sv
module ptr_addr_unit_chk
  import ptr_pkg::*;
#(
  parameter int PSEL_W   = 2,
  parameter int NUM_PTRS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ptr_go,
  input logic [PSEL_W-1:0] ptr_sel,
  input logic [2:0]        ptr_mode,
  input logic              ea_valid,
  input logic              pair_upd
);

  logic cmd_ok;
  logic upd_mode;
  assign cmd_ok   = ptr_go && ({1'b0, ptr_sel} < (PSEL_W+1)'(NUM_PTRS)) && (ptr_mode <= PM_LAST);
  assign upd_mode = (ptr_mode == PM_POSTINC) || (ptr_mode == PM_PREDEC) ||
                    (ptr_mode == PM_ADD) || (ptr_mode == PM_SUB);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!ea_valid && !pair_upd));

  assert_plain_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && ptr_mode == PM_PLAIN) |=> (ea_valid && !pair_upd));

  assert_postinc_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && ptr_mode == PM_POSTINC) |=> (ea_valid && pair_upd));

  assert_predec_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && ptr_mode == PM_PREDEC) |=> (ea_valid && pair_upd));

  assert_disp_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && ptr_mode == PM_DISP) |=> (ea_valid && !pair_upd));

  assert_addsub_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && (ptr_mode == PM_ADD || ptr_mode == PM_SUB)) |=> (!ea_valid && pair_upd));

  assert_upd_source_R8: assert property (@(posedge clk) disable iff (rst)
    (!(cmd_ok && upd_mode)) |=> !pair_upd);

  assert_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ok) |=> (!ea_valid && !pair_upd));

endmodule

bind ptr_addr_unit ptr_addr_unit_chk #(
  .PSEL_W   (PSEL_W),
  .NUM_PTRS (NUM_PTRS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ptr_go   (ptr_go),
  .ptr_sel  (ptr_sel),
  .ptr_mode (ptr_mode),
  .ea_valid (ea_valid),
  .pair_upd (pair_upd)
);

// File: tb/ptr_addr_unit_tb.sv
module ptr_addr_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int BASE = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [7:0]  rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, ptr_go = 1'b0;
  logic [1:0]  ptr_sel = '0;
  logic [2:0]  ptr_mode = '0;
  logic [5:0]  ptr_imm = '0;
  logic [15:0] ea_out;
  logic        ea_valid, pair_upd;

  ptr_addr_unit u_dut (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_go(ptr_go), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_imm(ptr_imm),
    .ea_out(ea_out), .ea_valid(ea_valid), .pair_upd(pair_upd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          vld;
    logic [15:0] ea;
    bit          upd;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  logic [7:0]  m [NREG];
  int          n_chk = 0;
  int          n_fail = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard items in the cycle they fall due
  always @(negedge clk) begin
    if (!rst) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        exp_t e;
        e = sbq.pop_front();
        check(e.req, "ea_valid", 32'(ea_valid), 32'(e.vld));
        if (e.vld) check(e.req, "ea_out", 32'(ea_out), 32'(e.ea));
        check({e.req, "/R8"}, "pair_upd", 32'(pair_upd), 32'(e.upd));
      end else if (ea_valid || pair_upd) begin
        check("R8", "idle outputs", {30'd0, ea_valid, pair_upd}, 32'd0);
      end
    end
  end

  // compute expectation and drive a command in the current half cycle
  task automatic ptr_now(int sel, int mode, int imm, string req);
    logic [15:0] p, nv, ea;
    bit vld, upd;
    int lo;
    ptr_go = 1'b1; ptr_sel = 2'(sel); ptr_mode = 3'(mode); ptr_imm = 6'(imm);
    vld = 0; upd = 0; ea = '0; nv = '0;
    if (sel < 3 && mode < 6) begin
      lo = BASE + 2*sel;
      p  = {m[lo+1], m[lo]};
      case (mode)
        0: begin vld = 1; ea = p; end
        1: begin vld = 1; ea = p; upd = 1; nv = p + 16'd1; end
        2: begin vld = 1; nv = p - 16'd1; ea = nv; upd = 1; end
        3: begin vld = 1; ea = p + 16'(imm); end
        4: begin upd = 1; nv = p + 16'(imm); end
        default: begin upd = 1; nv = p - 16'(imm); end
      endcase
      if (upd) begin m[lo] = nv[7:0]; m[lo+1] = nv[15:8]; end
    end
    sbq.push_back('{cyc + 1, vld, ea, upd, req});
  endtask

  task automatic ptr_cmd(int sel, int mode, int imm, string req);
    @(negedge clk);
    wr_en = 1'b0;
    ptr_now(sel, mode, imm, req);
  endtask

  task automatic idle();
    @(negedge clk);
    ptr_go = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(int sel, logic [7:0] d);
    @(negedge clk);
    ptr_go = 1'b0; wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
    m[sel] = d;
  endtask

  task automatic rd(int sa, int sb, string req);
    @(negedge clk);
    ptr_go = 1'b0; wr_en = 1'b0;
    rd_a_sel = 5'(sa); rd_b_sel = 5'(sb);
    @(negedge clk);
    check(req, $sformatf("rd_a R%0d", sa), 32'(rd_a_data), 32'(m[sa]));
    check(req, $sformatf("rd_b R%0d", sb), 32'(rd_b_data), 32'(m[sb]));
  endtask

  task automatic set_pair(int sel, logic [15:0] v);
    wr(BASE + 2*sel, v[7:0]);
    wr(BASE + 2*sel + 1, v[15:8]);
    idle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) m[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1", "ea_out", 32'(ea_out), 32'd0);
    check("R1", "ea_valid", 32'(ea_valid), 32'd0);
    check("R1", "pair_upd", 32'(pair_upd), 32'd0);
    rst = 1'b0;
    rd(0, 31, "R1");
    rd(26, 29, "R1");

    // R2: ordinary write and dual read
    wr(5, 8'h3C);
    wr(17, 8'hC3);
    rd(5, 17, "R2");
    // R2: read-first on same-edge write
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 5'd5; wr_data = 8'h99; rd_a_sel = 5'd5; rd_b_sel = 5'd17;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2", "read-first", 32'(rd_a_data), 32'h3C);
    m[5] = 8'h99;
    rd(5, 5, "R2");

    // R3: plain indirect on each pair, pair remains
    set_pair(0, 16'h1234);
    set_pair(1, 16'hFFFF);
    set_pair(2, 16'h0000);
    ptr_cmd(0, 0, 0, "R3"); idle();
    ptr_cmd(1, 0, 0, "R3"); idle();
    ptr_cmd(2, 0, 0, "R3"); idle();
    rd(26, 27, "R3");

    // R4: post-increment wraps 0xFFFF -> 0x0000
    ptr_cmd(1, 1, 0, "R4"); idle();
    rd(28, 29, "R4");
    // R5: pre-decrement wraps 0x0000 -> 0xFFFF
    ptr_cmd(2, 2, 0, "R5"); idle();
    rd(30, 31, "R5");

    // R6: displacement, max and zero, pointer unchanged
    ptr_cmd(0, 3, 63, "R6"); idle();
    ptr_cmd(0, 3, 0, "R6"); idle();
    rd(26, 27, "R6");

    // R7: add with carry into high byte, subtract with borrow
    set_pair(0, 16'h00F0);
    ptr_cmd(0, 4, 63, "R7"); idle();
    rd(26, 27, "R7");
    ptr_cmd(0, 5, 63, "R7"); idle();
    rd(26, 27, "R7");
    set_pair(2, 16'h0100);
    ptr_cmd(2, 5, 1, "R7"); idle();
    rd(30, 31, "R7");

    // R4/R5/R8: back-to-back updates on one pair
    ptr_cmd(0, 1, 0, "R4");
    ptr_cmd(0, 1, 0, "R4");
    ptr_cmd(0, 1, 0, "R4");
    ptr_cmd(0, 2, 0, "R5");
    idle();
    rd(26, 27, "R8");

    // R10: ignored commands leave pairs and outputs quiet
    ptr_cmd(3, 1, 5, "R10");
    ptr_cmd(1, 6, 5, "R10");
    ptr_cmd(2, 7, 5, "R10");
    idle();
    rd(26, 27, "R10");
    rd(28, 29, "R10");
    rd(30, 31, "R10");

    // R9: write-back beats same-edge ordinary write
    @(negedge clk);
    ptr_now(0, 1, 0, "R9");
    wr_en = 1'b1; wr_sel = 5'd27; wr_data = 8'hAA;
    idle();
    rd(26, 27, "R9");
    // R9: plain mode does not block an ordinary write to the pair
    @(negedge clk);
    ptr_now(1, 0, 0, "R9");
    wr_en = 1'b1; wr_sel = 5'd28; wr_data = 8'h5A;
    m[28] = 8'h5A;
    idle();
    rd(28, 29, "R9");

    repeat (3) @(negedge clk);
    check("R8", "scoreboard drained", 32'(sbq.size()), 32'd0);
    finish_run();
  end

endmodule